// File: doc/BRIEF.md
# Timing Endpoint Command Receiver

This block sits in a timing endpoint and reads the decoded byte stream that the timing master sends down a shared fibre. Each byte comes with a control-character flag and a decode error flag. The receiver splits the stream into two kinds of message.

Broadcast messages all have the same size. Every endpoint on the fibre acts on them, and their content (a timestamp word or a trigger) is presented on a strobe a fixed number of cycles after the message starts. Addressed messages vary in length and are meant for one endpoint only. The receiver acts on one only when its address byte equals the endpoint's configured address. Such a message can load a cable-delay compensation value, or switch the upstream transmitter on or off.

The upstream transmitter starts out disabled. It only turns on when the master explicitly enables it, so many endpoints can share one passively split return fibre without talking over each other. When a message contains a byte with the error flag or an unexpected control character, the whole message is dropped and an error count goes up.

Top module: `tep_cmd_rx`

## Requirements
- R1: After reset, `tx_en` is 0, `delay_val` is 0, `err_cnt` is 0 and `bcast_valid` is 0.
- R2: A message begins with the byte 0xBC with `rx_k`=1, followed by a class byte. If bit 7 of the class byte is 0, the message is a broadcast. FIX_LEN payload bytes follow the class byte, most significant first. At the end, `bcast_valid` pulses for exactly one cycle, with `bcast_cmd` equal to class bits 3:0 and `bcast_data` holding the payload.
- R3: The `bcast_valid` pulse always falls in the clock cycle FIX_LEN+2 cycles after the cycle that carried the start byte. This holds even when another message ended in the cycle just before that start byte.
- R4: If bit 7 of the class byte is 1, the message is addressed. A length byte N comes next, then an address byte, then N payload bytes. If the address byte differs from `my_addr`, all N+3 bytes after the start are consumed and nothing changes: `tx_en`, `delay_val` and `bcast_valid` keep their values.
- R5: A matching addressed message with class bits 3:0 = 2 sets `tx_en` to 1, and one with bits 3:0 = 3 clears it. Either takes effect on the clock edge that samples the final byte of the message. Any length is allowed, including N=0.
- R6: A matching addressed message with class bits 3:0 = 1 and N of at least 1 loads the first payload byte into `delay_val`. The load happens on the edge that samples the final byte, so any later payload bytes are consumed and ignored.
- R7: If a byte after the start byte arrives with `rx_err`=1 or with `rx_k`=1, the message is aborted. `err_cnt` goes up by one, no strobe is produced, `delay_val` and `tx_en` stay as they were, and the receiver goes back to hunting for a start byte.
- R8: While no message is in progress, bytes with `rx_err`=1 and bytes other than the start byte are ignored. They leave `err_cnt` and every output unchanged.
- R9: `err_cnt` saturates at its all-ones value and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Decoded byte |
| rx_k | input | 1 | Byte is a control character |
| rx_err | input | 1 | Decode or disparity error on this byte |
| my_addr | input | 8 | This endpoint's address |
| bcast_valid | output | 1 | One-cycle strobe for a received broadcast |
| bcast_cmd | output | 4 | Broadcast type from the class byte |
| bcast_data | output | FIX_LEN*8 | Broadcast payload |
| delay_val | output | 8 | Delay compensation setting |
| tx_en | output | 1 | Upstream transmitter enable |
| err_cnt | output | ERR_W | Aborted-message count, saturating |

## Verification
The assertions assume that every byte the receiver acts on comes with `rx_err` and `rx_k` low, and that no state change can be traced back to a flagged byte. They also assume the master never sends a broadcast shorter than two cycles, so a strobe can never be seen on two cycles in a row. The directed stimulus corrupts only bytes that fall inside a message. It places idle-time errors and stray bytes between messages, never inside one, and each test then checks that the outputs stayed put. Messages are driven byte by byte on the falling edge, and a new message is sent straight after the previous one ends, to show that the broadcast latency does not depend on the traffic that came before it.

// File: rtl/tep_cmd_rx.sv
module tep_cmd_rx #(
  parameter int FIX_LEN = 4,
  parameter int ERR_W   = 8,
  parameter logic [7:0] START = 8'hBC
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             rx_data,
  input  logic                   rx_k,
  input  logic                   rx_err,
  input  logic [7:0]             my_addr,
  output logic                   bcast_valid,
  output logic [3:0]             bcast_cmd,
  output logic [FIX_LEN*8-1:0]   bcast_data,
  output logic [7:0]             delay_val,
  output logic                   tx_en,
  output logic [ERR_W-1:0]       err_cnt
);
  localparam int FW = FIX_LEN * 8;

  typedef enum logic [2:0] {HUNT, CLS, LEN, ADR, FPAY, VPAY} st_t;

  st_t        st;
  logic [7:0] cls, len, cnt, first;
  logic       hit;
  logic [FW-1:0] shreg;

  logic       clean, hit_now, last_var, apply;
  logic [7:0] arg;

  assign clean    = !rx_err && !rx_k;
  assign hit_now  = (st == ADR) ? (rx_data == my_addr) : hit;
  assign last_var = (st == ADR && len == 8'd0) || (st == VPAY && cnt == len - 8'd1);
  assign apply    = clean && last_var && hit_now;
  assign arg      = (st == VPAY && cnt == 8'd0) ? rx_data : first;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= HUNT;
      cls         <= '0;
      len         <= '0;
      cnt         <= '0;
      first       <= '0;
      hit         <= 1'b0;
      shreg       <= '0;
      bcast_valid <= 1'b0;
      bcast_cmd   <= '0;
      bcast_data  <= '0;
      delay_val   <= '0;
      tx_en       <= 1'b0;
      err_cnt     <= '0;
    end else begin
      bcast_valid <= 1'b0;
      if (st != HUNT && !clean) begin
        st <= HUNT;
        if (err_cnt != '1) err_cnt <= err_cnt + 1'b1;
      end else begin
        case (st)
          HUNT: if (rx_k && !rx_err && rx_data == START) st <= CLS;
          CLS: begin
            cls <= rx_data;
            cnt <= '0;
            st  <= rx_data[7] ? LEN : FPAY;
          end
          FPAY: begin
            shreg <= {shreg[FW-9:0], rx_data};
            cnt   <= cnt + 8'd1;
            if (cnt == 8'(FIX_LEN - 1)) begin
              st          <= HUNT;
              bcast_valid <= 1'b1;
              bcast_cmd   <= cls[3:0];
              bcast_data  <= {shreg[FW-9:0], rx_data};
            end
          end
          LEN: begin
            len <= rx_data;
            st  <= ADR;
          end
          ADR: begin
            hit <= hit_now;
            cnt <= '0;
            st  <= (len == 8'd0) ? HUNT : VPAY;
          end
          VPAY: begin
            if (cnt == 8'd0) first <= rx_data;
            cnt <= cnt + 8'd1;
            if (cnt == len - 8'd1) st <= HUNT;
          end
          default: st <= HUNT;
        endcase
        if (apply) begin
          case (cls[3:0])
            4'd1: if (st == VPAY) delay_val <= arg;
            4'd2: tx_en <= 1'b1;
            4'd3: tx_en <= 1'b0;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

module tep_cmd_rx_chk #(
  parameter int FIX_LEN = 4,
  parameter int ERR_W   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_k,
  input logic             rx_err,
  input logic             bcast_valid,
  input logic [7:0]       delay_val,
  input logic             tx_en,
  input logic [ERR_W-1:0] err_cnt
);
  assert_bcast_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_valid |=> !bcast_valid);
  assert_bcast_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_valid |-> $past(!rx_err && !rx_k));
  assert_delay_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(delay_val) |-> $past(!rx_err && !rx_k));
  assert_txen_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_en) |-> $past(!rx_err && !rx_k));
  assert_err_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_cnt) |-> err_cnt == $past(err_cnt) + 1'b1);
  assert_err_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt == '1 |=> err_cnt == '1);
endmodule

bind tep_cmd_rx tep_cmd_rx_chk #(.FIX_LEN(FIX_LEN), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_k(rx_k), .rx_err(rx_err),
  .bcast_valid(bcast_valid), .delay_val(delay_val), .tx_en(tx_en), .err_cnt(err_cnt)
);

// File: tb/tep_cmd_rx_tb.sv
`timescale 1ns/1ps
module tep_cmd_rx_tb;
  localparam int FIX_LEN = 4;
  localparam int ERR_W   = 8;
  localparam logic [7:0] ME = 8'h2A;

  logic clk = 0, rst_n = 0;
  logic [7:0] rx_data = 0;
  logic rx_k = 0, rx_err = 0;
  logic bcast_valid;
  logic [3:0] bcast_cmd;
  logic [FIX_LEN*8-1:0] bcast_data;
  logic [7:0] delay_val;
  logic tx_en;
  logic [ERR_W-1:0] err_cnt;

  int checks = 0, errors = 0;
  int cyc = 0, t_start = 0;
  int seen = 0, v_cyc = 0;
  logic [3:0] v_cmd;
  logic [31:0] v_data;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (bcast_valid) begin
    seen++; v_cyc = cyc; v_cmd = bcast_cmd; v_data = bcast_data;
  end

  tep_cmd_rx #(.FIX_LEN(FIX_LEN), .ERR_W(ERR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_k(rx_k), .rx_err(rx_err),
    .my_addr(ME), .bcast_valid(bcast_valid), .bcast_cmd(bcast_cmd),
    .bcast_data(bcast_data), .delay_val(delay_val), .tx_en(tx_en), .err_cnt(err_cnt)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d, input bit k = 0, input bit e = 0);
    @(negedge clk); rx_data = d; rx_k = k; rx_err = e;
  endtask

  task automatic settle();
    repeat (4) put(8'h00);
    @(posedge clk); #1;
  endtask

  task automatic start_msg();
    put(8'hBC, 1);
    @(posedge clk); #1;
    t_start = cyc; seen = 0;
  endtask

  task automatic send_bcast(input logic [3:0] c, input logic [31:0] d, input int bad = -1);
    start_msg();
    put({4'h0, c}, 0, bad == 0);
    for (int i = 0; i < FIX_LEN; i++) put(d[31-8*i -: 8], 0, bad == i + 1);
  endtask

  task automatic send_addr(input logic [3:0] c, input logic [7:0] a, input logic [7:0] n,
                           input logic [7:0] b0, input int bad = -1);
    start_msg();
    put({4'h8, c}); put(n); put(a);
    for (int i = 0; i < n; i++) put(i == 0 ? b0 : 8'hE0 + 8'(i), 0, bad == i);
  endtask

  task automatic t_reset();
    chk(tx_en == 0, "R1 tx_en", tx_en, 0);
    chk(delay_val == 0, "R1 delay_val", delay_val, 0);
    chk(err_cnt == 0, "R1 err_cnt", err_cnt, 0);
    chk(bcast_valid == 0, "R1 bcast_valid", bcast_valid, 0);
  endtask

  task automatic t_bcast();
    send_bcast(4'h5, 32'h11223344); settle();
    chk(seen == 1, "R2 one strobe", seen, 1);
    chk(v_cmd == 4'h5, "R2 cmd", v_cmd, 5);
    chk(v_data == 32'h11223344, "R2 data", v_data, 32'h11223344);
    chk(v_cyc - t_start == FIX_LEN + 1, "R3 latency", v_cyc - t_start, FIX_LEN + 1);
    send_bcast(4'hC, 32'hA5F00F5A); settle();
    chk(v_data == 32'hA5F00F5A && v_cmd == 4'hC, "R2 second pattern", v_data, 32'hA5F00F5A);
  endtask

  task automatic t_back_to_back();
    send_addr(4'h7, ME, 8'd3, 8'h01);
    send_bcast(4'h9, 32'hDEADBEEF); settle();
    chk(v_cyc - t_start == FIX_LEN + 1, "R3 latency after addressed", v_cyc - t_start, FIX_LEN + 1);
    send_bcast(4'h1, 32'h01020304);
    send_bcast(4'h2, 32'h0A0B0C0D); settle();
    chk(v_cyc - t_start == FIX_LEN + 1, "R3 latency after broadcast", v_cyc - t_start, FIX_LEN + 1);
    chk(v_data == 32'h0A0B0C0D, "R2 back-to-back data", v_data, 32'h0A0B0C0D);
  endtask

  task automatic t_tx();
    send_addr(4'h2, ME, 8'd0, 8'h00); settle();
    chk(tx_en == 1, "R5 enable len0", tx_en, 1);
    send_addr(4'h3, ME, 8'd2, 8'h00); settle();
    chk(tx_en == 0, "R5 disable len2", tx_en, 0);
    send_addr(4'h2, ME, 8'd1, 8'h00); settle();
    chk(tx_en == 1, "R5 enable len1", tx_en, 1);
  endtask

  task automatic t_mismatch();
    send_addr(4'h3, 8'h2B, 8'd0, 8'h00); settle();
    chk(tx_en == 1, "R4 foreign disable", tx_en, 1);
    send_addr(4'h1, 8'h55, 8'd2, 8'h77); settle();
    chk(delay_val == 0, "R4 foreign delay", delay_val, 0);
    send_addr(4'h3, 8'hAA, 8'd1, 8'hBC); settle();
    chk(tx_en == 1 && seen == 0, "R4 foreign payload looks like start", tx_en, 1);
  endtask

  task automatic t_delay();
    send_addr(4'h1, ME, 8'd3, 8'h37); settle();
    chk(delay_val == 8'h37, "R6 delay len3", delay_val, 8'h37);
    send_addr(4'h1, ME, 8'd1, 8'hC4); settle();
    chk(delay_val == 8'hC4, "R6 delay len1", delay_val, 8'hC4);
    send_addr(4'h1, ME, 8'd0, 8'h00); settle();
    chk(delay_val == 8'hC4, "R6 delay len0 no load", delay_val, 8'hC4);
  endtask

  task automatic t_errors();
    automatic logic [ERR_W-1:0] e0 = err_cnt;
    send_bcast(4'h6, 32'h99999999, 3); settle();
    chk(seen == 0, "R7 aborted broadcast strobe", seen, 0);
    chk(err_cnt == e0 + 1, "R7 count", err_cnt, e0 + 1);
    send_addr(4'h1, ME, 8'd2, 8'h10, 1); settle();
    chk(delay_val == 8'hC4, "R7 delay unchanged", delay_val, 8'hC4);
    chk(err_cnt == e0 + 2, "R7 count 2", err_cnt, e0 + 2);
    start_msg(); put(8'h83); put(8'h00); put(8'hBC, 1); settle();
    chk(tx_en == 1, "R7 K-char abort keeps tx_en", tx_en, 1);
    chk(err_cnt == e0 + 3, "R7 K-char counted", err_cnt, e0 + 3);
  endtask

  task automatic t_idle();
    automatic logic [ERR_W-1:0] e0 = err_cnt;
    put(8'h00, 0, 1); put(8'h1C, 1); put(8'h55); put(8'hBC, 1, 1); put(8'h02); settle();
    chk(err_cnt == e0, "R8 idle errors ignored", err_cnt, e0);
    chk(seen == 0 && tx_en == 1 && delay_val == 8'hC4, "R8 outputs unchanged", tx_en, 1);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 260; i++) begin start_msg(); put(8'h00, 0, 1); end
    settle();
    chk(err_cnt == '1, "R9 saturate", err_cnt, 255);
    send_bcast(4'h4, 32'h44444444); settle();
    chk(seen == 1 && v_data == 32'h44444444, "R2 works after errors", v_data, 32'h44444444);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk); rst_n = 1;
    t_bcast();
    t_back_to_back();
    t_tx();
    t_mismatch();
    t_delay();
    t_errors();
    t_idle();
    t_saturate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule